// File: doc/BRIEF.md
# Crop Window and Ratio Decimator

This block sits in a video capture path. It receives a pixel stream framed by a frame-start strobe and a line-start strobe. First it cuts a programmable rectangle out of each frame. It then thins the rows and columns inside that rectangle by two independent N/M ratios. A third N/M ratio decides which whole frames are captured at all. Every decision is keep or drop: pixel values pass through unchanged, with no filtering and no interpolation.

Each ratio is handled by an accumulator. The accumulator adds N at every step. When the sum reaches M, the item is kept and M is taken off the sum. This spreads the kept items evenly: over k steps, the number kept is floor(k·N/M). Configuration is sampled once at each frame start, so a frame is never processed with mixed settings.

A one-shot mode stops capture after one complete frame. Capture resumes only after the enable input has been driven low.

Top module: `crop_decim`

## Requirements
- R1: After reset, `out_valid` and `frame_done` are low. Pixels that arrive before the first `frame_start` produce no output.
- R2: A pixel is accepted only when `pix_valid` is high and neither strobe is high in that cycle. Rows are numbered from 0, starting at the first `line_start` after `frame_start`. Columns count the accepted pixels since the last `line_start`. Only pixels in columns [`crop_x`, `crop_x+crop_w`) of rows [`crop_y`, `crop_y+crop_h`) may pass. A passed pixel appears on `out_data` with `out_valid` high exactly one cycle after it is accepted.
- R3: Column thinning uses an accumulator that is cleared at each `line_start` and stepped once per in-window pixel of a kept row. The step keeps the pixel when acc+`h_num` ≥ `h_den`; acc then becomes acc+`h_num`−`h_den`, or 0 if that result is still ≥ `h_den`. Otherwise acc becomes acc+`h_num` and the pixel is dropped. Both factors are 16-bit.
- R4: Row thinning uses the same rule with `v_num`/`v_den`. It steps once per in-window row of a captured frame, and its accumulator is cleared at `frame_start`.
- R5: Frame thinning uses the same rule with the 6-bit `f_num`/`f_den`. It steps at each `frame_start` while capture is on. Its accumulator is cleared only by reset.
- R6: For any of the three ratios, N = 0, M = 0 or N ≥ M keeps every item and leaves that accumulator unchanged.
- R7: Crop and ratio inputs are sampled in the `frame_start` cycle. Changes to them during a frame have no effect on that frame.
- R8: `frame_done` is a one-cycle pulse. It appears in the same cycle as the output slot of the last in-window pixel of a captured frame, whether or not that pixel is kept. An empty window (`crop_w` or `crop_h` equal to 0) never produces the pulse.
- R9: If `shutter_en` is high when `frame_done` is produced, no further frame is captured until `cap_enable` has been low for at least one cycle.
- R10: A frame is captured only if `cap_enable` is high, and the one-shot stop is clear, in its `frame_start` cycle. A pixel presented together with a strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_enable | input | 1 | Capture on; sampled at each frame start |
| shutter_en | input | 1 | Stop after one complete captured frame |
| pix_valid | input | 1 | Pixel present on `pix_data` |
| pix_data | input | PIX_W | Pixel value |
| line_start | input | 1 | Strobe: a new row begins |
| frame_start | input | 1 | Strobe: a new frame begins |
| crop_x | input | 12 | Window left column |
| crop_y | input | 11 | Window top row |
| crop_w | input | 12 | Window width in pixels |
| crop_h | input | 11 | Window height in rows |
| h_num | input | 16 | Column ratio numerator |
| h_den | input | 16 | Column ratio denominator |
| v_num | input | 16 | Row ratio numerator |
| v_den | input | 16 | Row ratio denominator |
| f_num | input | 6 | Frame ratio numerator |
| f_den | input | 6 | Frame ratio denominator |
| out_valid | output | 1 | Kept pixel on `out_data` |
| out_data | output | PIX_W | Kept pixel value |
| frame_done | output | 1 | End of a captured frame |

## Verification
The hardest situation to reach from the ports is the frame-ratio accumulator carrying state across frames, combined with the one-shot stop. Whether a frame is captured depends on every earlier `frame_start` that arrived while capture was on. The stimulus therefore runs a series of frames with a 1/3 frame ratio and checks that only the third frame produces pixels and a `frame_done`. It then arms the one-shot mode, confirms that the next frame is silent, and toggles `cap_enable` to restart capture. A frame that changes the column ratio in its middle, and rows that put a pixel on the same cycle as `line_start`, cover the sampling and priority rules.

// File: rtl/crop_decim_pkg.sv
package crop_decim_pkg;
    parameter int XW = 12;   // horizontal position and width
    parameter int YW = 11;   // vertical position and height
    parameter int SW = 16;   // spatial ratio factors
    parameter int TW = 6;    // frame ratio factors

    typedef struct packed {
        logic [XW-1:0] x0;
        logic [YW-1:0] y0;
        logic [XW-1:0] w;
        logic [YW-1:0] h;
        logic [SW-1:0] hn;
        logic [SW-1:0] hm;
        logic [SW-1:0] vn;
        logic [SW-1:0] vm;
        logic [TW-1:0] fn;
        logic [TW-1:0] fm;
    } frame_cfg_t;
endpackage

// File: rtl/crop_decim_ratio.sv
// N/M keep-or-drop accumulator shared by the column, row and frame paths.
module crop_decim_ratio #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         keep
);
    localparam int AW = W + 1;

    logic [W-1:0]  acc_q, acc_d;
    logic          pass;
    logic [AW-1:0] sum, rem, den_x;

    always_comb begin
        pass  = (num == '0) || (den == '0) || (num >= den);
        den_x = {1'b0, den};
        sum   = {1'b0, acc_q} + {1'b0, num};
        rem   = sum - den_x;
        keep  = pass || (sum >= den_x);
        acc_d = acc_q;
        if (clr) begin
            acc_d = '0;
        end else if (step && !pass) begin
            if (sum >= den_x) begin
                // clamp covers an accumulator left large by a factor change
                acc_d = (rem >= den_x) ? '0 : rem[W-1:0];
            end else begin
                acc_d = sum[W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R3/R4/R5: after a real step the remainder stays below the denominator
    a_r3_acc_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        $past(step && !clr && !pass) |-> (acc_q < $past(den)));
endmodule

// File: rtl/crop_decim_window.sv
// Row/column position tracking and crop-window membership.
module crop_decim_window #(
    parameter int XW = 12,
    parameter int YW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          line_start,
    input  logic          pix_valid,
    input  logic [XW-1:0] x0,
    input  logic [XW-1:0] w,
    input  logic [YW-1:0] y0,
    input  logic [YW-1:0] h,
    output logic          new_row_in,
    output logic          pix_in,
    output logic          pix_last
);
    localparam int CW = XW + 1;
    localparam int RW = YW + 1;
    localparam logic [CW-1:0] COL_MAX = '1;
    localparam logic [RW-1:0] ROW_MAX = '1;

    typedef struct packed {
        logic [RW-1:0] row;
        logic [CW-1:0] col;
        logic          started;
        logic          row_in;
    } pos_t;

    pos_t          st_q, st_d;
    logic [CW-1:0] x_lo, x_hi;
    logic [RW-1:0] y_lo, y_hi, row_next;
    logic          take, col_in;

    always_comb begin
        x_lo     = {1'b0, x0};
        x_hi     = {1'b0, x0} + {1'b0, w};
        y_lo     = {1'b0, y0};
        y_hi     = {1'b0, y0} + {1'b0, h};
        row_next = st_q.started ? ((st_q.row == ROW_MAX) ? st_q.row : st_q.row + 1'b1) : '0;
        new_row_in = line_start && (row_next >= y_lo) && (row_next < y_hi);
        take     = pix_valid && !frame_start && !line_start;
        col_in   = (st_q.col >= x_lo) && (st_q.col < x_hi);
        pix_in   = take && st_q.row_in && col_in;
        pix_last = pix_in && (st_q.row == y_hi - 1'b1) && (st_q.col == x_hi - 1'b1);

        st_d = st_q;
        if (frame_start) begin
            st_d.row     = '0;
            st_d.col     = '0;
            st_d.started = 1'b0;
            st_d.row_in  = 1'b0;
        end else if (line_start) begin
            st_d.row     = row_next;
            st_d.col     = '0;
            st_d.started = 1'b1;
            st_d.row_in  = new_row_in;
        end else if (take && st_q.col != COL_MAX) begin
            st_d.col = st_q.col + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: column count restarts after every line strobe
    a_r2_col_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $past(line_start || frame_start) |-> (st_q.col == '0));
endmodule

// File: rtl/crop_decim.sv
module crop_decim
    import crop_decim_pkg::*;
#(
    parameter int PIX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_enable,
    input  logic             shutter_en,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             line_start,
    input  logic             frame_start,
    input  logic [XW-1:0]    crop_x,
    input  logic [YW-1:0]    crop_y,
    input  logic [XW-1:0]    crop_w,
    input  logic [YW-1:0]    crop_h,
    input  logic [SW-1:0]    h_num,
    input  logic [SW-1:0]    h_den,
    input  logic [SW-1:0]    v_num,
    input  logic [SW-1:0]    v_den,
    input  logic [TW-1:0]    f_num,
    input  logic [TW-1:0]    f_den,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_data,
    output logic             frame_done
);
    typedef struct packed {
        frame_cfg_t       cfg;
        logic             frame_on;
        logic             row_keep;
        logic             stopped;
        logic             out_valid;
        logic             eof;
        logic [PIX_W-1:0] out_data;
    } ctl_t;

    ctl_t       st_q, st_d;
    frame_cfg_t cfg_in;
    logic       active, new_row_in, pix_in, pix_last;
    logic       fkeep, vkeep, hkeep;

    always_comb begin
        cfg_in = '{x0: crop_x, y0: crop_y, w: crop_w, h: crop_h,
                   hn: h_num, hm: h_den, vn: v_num, vm: v_den,
                   fn: f_num, fm: f_den};
        active = cap_enable && !st_q.stopped;
    end

    crop_decim_window #(.XW(XW), .YW(YW)) u_win (
        .clk(clk), .rst_n(rst_n),
        .frame_start(frame_start), .line_start(line_start), .pix_valid(pix_valid),
        .x0(st_q.cfg.x0), .w(st_q.cfg.w), .y0(st_q.cfg.y0), .h(st_q.cfg.h),
        .new_row_in(new_row_in), .pix_in(pix_in), .pix_last(pix_last)
    );

    crop_decim_ratio #(.W(TW)) u_frame_ratio (
        .clk(clk), .rst_n(rst_n), .clr(1'b0),
        .step(frame_start && active),
        .num(f_num), .den(f_den), .keep(fkeep)
    );

    crop_decim_ratio #(.W(SW)) u_row_ratio (
        .clk(clk), .rst_n(rst_n), .clr(frame_start),
        .step(new_row_in && st_q.frame_on),
        .num(st_q.cfg.vn), .den(st_q.cfg.vm), .keep(vkeep)
    );

    crop_decim_ratio #(.W(SW)) u_col_ratio (
        .clk(clk), .rst_n(rst_n), .clr(line_start),
        .step(pix_in && st_q.frame_on && st_q.row_keep),
        .num(st_q.cfg.hn), .den(st_q.cfg.hm), .keep(hkeep)
    );

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = 1'b0;
        st_d.eof       = 1'b0;
        if (frame_start) begin
            st_d.cfg      = cfg_in;
            st_d.frame_on = active && fkeep;
            st_d.row_keep = 1'b0;
        end else if (line_start) begin
            st_d.row_keep = new_row_in && vkeep;
        end
        if (pix_in && st_q.frame_on && st_q.row_keep && hkeep) begin
            st_d.out_valid = 1'b1;
            st_d.out_data  = pix_data;
        end
        if (pix_last && st_q.frame_on) begin
            st_d.eof      = 1'b1;
            st_d.frame_on = 1'b0;
            if (shutter_en) st_d.stopped = 1'b1;
        end
        if (!cap_enable) st_d.stopped = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.out_valid;
    assign out_data   = st_q.out_data;
    assign frame_done = st_q.eof;

    // R2: output only follows an accepted pixel one cycle earlier
    a_r2_out_follows_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(pix_valid && !frame_start && !line_start));
    // R8: end-of-frame is a single-cycle pulse
    a_r8_eof_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
    // R9: a stopped capture never has a frame in progress
    a_r9_stop_excludes_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.frame_on && st_q.stopped));
    // R7: shadow configuration only moves after a frame strobe
    a_r7_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_start) |-> $stable(st_q.cfg));
endmodule

// File: tb/crop_decim_test.sv
`timescale 1ns/100ps
module crop_decim_test;
    localparam int PIX_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cap_enable = 1'b0, shutter_en = 1'b0;
    logic pix_valid = 1'b0, line_start = 1'b0, frame_start = 1'b0;
    logic [PIX_W-1:0] pix_data = '0;
    logic [11:0] crop_x = '0, crop_w = '0;
    logic [10:0] crop_y = '0, crop_h = '0;
    logic [15:0] h_num = '0, h_den = '0, v_num = '0, v_den = '0;
    logic [5:0]  f_num = '0, f_den = '0;
    logic out_valid, frame_done;
    logic [PIX_W-1:0] out_data;

    int tests = 0, fails = 0;
    int exp_eof = 0, act_eof = 0;
    int facc = 0;
    bit stopped_m = 0;
    bit done = 0;
    logic [PIX_W-1:0] sb[$];

    always #2.5 clk = ~clk;

    crop_decim #(.PIX_W(PIX_W)) uut (
        .clk(clk), .rst_n(rst_n), .cap_enable(cap_enable), .shutter_en(shutter_en),
        .pix_valid(pix_valid), .pix_data(pix_data), .line_start(line_start),
        .frame_start(frame_start), .crop_x(crop_x), .crop_y(crop_y),
        .crop_w(crop_w), .crop_h(crop_h), .h_num(h_num), .h_den(h_den),
        .v_num(v_num), .v_den(v_den), .f_num(f_num), .f_den(f_den),
        .out_valid(out_valid), .out_data(out_data), .frame_done(frame_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // accumulator rule of R3..R6
    function automatic bit ratio_step(inout int acc, input int n, input int m);
        int s;
        if (n == 0 || m == 0 || n >= m) return 1'b1;
        s = acc + n;
        if (s >= m) begin
            acc = (s - m >= m) ? 0 : s - m;
            return 1'b1;
        end
        acc = s;
        return 1'b0;
    endfunction

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (sb.size() == 0) chk(1'b0, "R2 unexpected pixel", int'(out_data), -1);
                else begin
                    logic [PIX_W-1:0] e;
                    e = sb.pop_front();
                    chk(out_data == e, "R2/R3/R4 pixel data", int'(out_data), int'(e));
                end
            end
            if (frame_done) act_eof++;
        end
    end

    task automatic set_enable(input bit v);
        @(negedge clk);
        cap_enable = v;
        if (!v) stopped_m = 0;
    endtask

    // drives one frame and queues the expected output
    task automatic run_frame(input int iw, input int ih, input bit gaps,
                             input bit mid_change, input bit strobe_px, input string req);
        int x0, y0, w, h, hn, hm, vn, vm, vacc, hacc;
        bit on, rk;
        @(negedge clk);
        frame_start = 1'b1;
        x0 = crop_x; y0 = crop_y; w = crop_w; h = crop_h;
        hn = h_num; hm = h_den; vn = v_num; vm = v_den;
        on = 0;
        if (cap_enable && !stopped_m) on = ratio_step(facc, f_num, f_den);
        vacc = 0;
        @(negedge clk);
        frame_start = 1'b0;
        if (mid_change) begin h_num = 16'd1; h_den = 16'd4; end // R7
        for (int r = 0; r < ih; r++) begin
            @(negedge clk);
            line_start = 1'b1;
            pix_valid  = strobe_px;   // R10: ignored pixel
            pix_data   = 16'hFFFF;
            rk = 0;
            if (on && r >= y0 && r < y0 + h) rk = ratio_step(vacc, vn, vm);
            hacc = 0;
            for (int c = 0; c < iw; c++) begin
                @(negedge clk);
                line_start = 1'b0;
                pix_valid  = 1'b1;
                pix_data   = {r[7:0], c[7:0]};
                if (rk && c >= x0 && c < x0 + w)
                    if (ratio_step(hacc, hn, hm)) sb.push_back({r[7:0], c[7:0]});
                if (on && r == y0 + h - 1 && c == x0 + w - 1) begin
                    exp_eof++;
                    on = 0;
                    if (shutter_en) stopped_m = 1;
                end
                if (gaps && (c % 3 == 1)) begin
                    @(negedge clk);
                    pix_valid = 1'b0;
                end
            end
            @(negedge clk);
            pix_valid = 1'b0;
        end
        repeat (4) @(negedge clk);
        chk(sb.size() == 0, {req, " missing pixels"}, sb.size(), 0);
        chk(act_eof == exp_eof, {req, " R8 frame_done count"}, act_eof, exp_eof);
        sb.delete();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            fails++; tests++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
        chk(frame_done == 1'b0, "R1 reset frame_done", int'(frame_done), 0);
        rst_n = 1'b1;
        // R1: pixels before any frame start are dropped
        cap_enable = 1'b1;
        crop_w = 12'd8; crop_h = 11'd8;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); pix_valid = 1'b1; pix_data = 16'(i);
        end
        @(negedge clk); pix_valid = 1'b0;
        repeat (3) @(negedge clk);

        // R2/R6: full window, zero factors pass everything
        crop_x = 0; crop_y = 0; crop_w = 8; crop_h = 6;
        run_frame(8, 6, 0, 0, 0, "R6 pass zero");
        // R2/R6: cropped window, N equal to M
        crop_x = 2; crop_y = 1; crop_w = 4; crop_h = 3;
        h_num = 5; h_den = 5; v_num = 7; v_den = 7;
        run_frame(10, 6, 0, 0, 0, "R2 crop");
        // R3/R4: 2/3 columns, 1/2 rows, gaps in the stream
        crop_x = 1; crop_y = 0; crop_w = 9; crop_h = 6;
        h_num = 2; h_den = 3; v_num = 1; v_den = 2;
        run_frame(11, 7, 1, 0, 0, "R3 R4 ratio");
        // R3: large 16-bit factors
        crop_x = 0; crop_y = 0; crop_w = 12; crop_h = 2;
        h_num = 30000; h_den = 50000; v_num = 0; v_den = 0;
        run_frame(12, 2, 0, 0, 0, "R3 wide");
        // R5: one frame in three
        h_num = 0; h_den = 0;
        crop_w = 4; crop_h = 2;
        f_num = 1; f_den = 3;
        for (int k = 0; k < 4; k++) run_frame(5, 3, 0, 0, 0, "R5 frame ratio");
        f_num = 0; f_den = 0;
        // R7: mid-frame change has no effect on the running frame
        h_num = 1; h_den = 1;
        run_frame(6, 3, 0, 1, 0, "R7 shadow");
        run_frame(6, 3, 0, 0, 0, "R7 next frame");
        // R10: pixel together with line strobe ignored
        h_num = 0; h_den = 0;
        run_frame(6, 3, 0, 0, 1, "R10 strobe pixel");
        // R8: empty window gives no frame_done
        crop_w = 0;
        run_frame(4, 3, 0, 0, 0, "R8 empty window");
        crop_w = 4;
        // R9: one-shot stop
        shutter_en = 1'b1;
        run_frame(5, 3, 0, 0, 0, "R9 first shot");
        run_frame(5, 3, 0, 0, 0, "R9 stopped");
        set_enable(0);
        set_enable(1);
        run_frame(5, 3, 0, 0, 0, "R9 restarted");
        shutter_en = 1'b0;
        // R10: disabled at frame start
        set_enable(0);
        run_frame(5, 3, 0, 0, 0, "R10 disabled");
        set_enable(1);
        run_frame(5, 3, 0, 0, 0, "R10 enabled");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule